// File: doc/BRIEF.md
# Bipolar Line Code Decoder with Violation Flagging

This block sits behind a clock and data recovery stage. Each clock it takes one received symbol, given as two pulse indicators: a positive-pulse bit and a negative-pulse bit. It produces a binary data stream. In DS3/STS-1 rate mode it undoes B3ZS zero substitution. In E3 rate mode it undoes HDB3 zero substitution. For every decoded bit it raises a line-code-violation flag on the same output cycle as the bit that caused the violation.

A format select picks one of two output formats. In binary format the block decodes the stream and reports violations. In bipolar format the block does not decode or check anything: the two pulse indicators pass through registered. Binary format has a compliance control that masks the excessive-zero rule. The bipolar-violation rules stay active when it is set.

A substitution code is only recognised once its closing violation pulse arrives. By then the earlier pulse of the code has already entered the delay line. The block therefore sends every symbol through a fixed four-stage alignment pipeline and clears that earlier pulse while it is still inside the pipeline. All outputs have the same latency of four clock cycles.

Top module: `line_code_decoder`

## Requirements
- R1: With `binary_sel_i` = 0 (bipolar format), `pos_o`/`neg_o` repeat `pos_i`/`neg_i` four cycles later. `data_o` and `viol_o` stay 0. No violation or zero-run checking applies.
- R2: With `binary_sel_i` = 1, the decoded bit appears on `data_o` and violations appear on `viol_o`. `pos_o` and `neg_o` stay 0.
- R3: Pulse classification: `pos_i`=1/`neg_i`=0 is a positive pulse and `pos_i`=0/`neg_i`=1 is a negative pulse. A pulse with the same polarity as the previous pulse is a bipolar violation (V). Any other pulse is a valid pulse (B), and the first pulse after reset is always B. In B3ZS mode (`hdb3_sel_i` = 0), a V directly after a pulse (B,V) is flagged and decoded as 1.
- R4: In HDB3 mode (`hdb3_sel_i` = 1), a V that follows a pulse directly (B,V) or after one zero (B,0,V) is flagged and decoded as 1.
- R5: In both modes, a V with the same polarity as the previous V is flagged. This applies even when that V closes a substitution.
- R6: With `exz_mask_i` = 0, the zero that makes a run of zeros since the last pulse reach 3 (B3ZS) or 4 (HDB3) is flagged. Only that zero is flagged.
- R7: With `exz_mask_i` = 1, no zero is ever flagged. The pulse rules of R3 to R5 still apply.
- R8: In B3ZS mode, 0,0,V and B,0,V (B a valid pulse) decode to three zeros and are not flagged unless R5 applies.
- R9: In HDB3 mode, 0,0,0,V and B,0,0,V (B a valid pulse) decode to four zeros and are not flagged unless R5 applies.
- R10: A symbol with both indicators set decodes as 1, is flagged, and leaves the last pulse polarity unchanged.
- R11: Every output refers to the input sampled four rising edges earlier. The violation flag appears together with the bit it concerns.
- R12: While `rst_n` is low, all outputs are 0. After reset the decoder history is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_i | input | 1 | Positive pulse received this symbol |
| neg_i | input | 1 | Negative pulse received this symbol |
| binary_sel_i | input | 1 | 1 = decode to binary, 0 = bipolar pass-through |
| hdb3_sel_i | input | 1 | 1 = HDB3 (E3) rules, 0 = B3ZS (DS3/STS-1) rules |
| exz_mask_i | input | 1 | 1 = suppress excessive-zero flagging |
| data_o | output | 1 | Decoded binary data |
| viol_o | output | 1 | Line code violation for the bit on data_o |
| pos_o | output | 1 | Registered positive pulse (bipolar format) |
| neg_o | output | 1 | Registered negative pulse (bipolar format) |

## Verification
Every result is due four rising edges after its symbol is captured. This includes a pulse that is later cleared by the V closing a substitution: that clearing happens inside the pipeline, before the pulse reaches the output. The bench drives symbols on falling edges. At each falling edge it compares the outputs against the vector fed four falling edges earlier. Each run ends with four flush symbols, so the last entries are checked without reading further ahead. A directed test confirms that a lone pulse is absent for three cycles and present on the fourth.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    // width of the saturating zero-run counter
    localparam int ZRUN_W   = 3;
    // substitution code lengths in symbols
    localparam int B3ZS_LEN = 3;
    localparam int HDB3_LEN = 4;

    // one symbol as it travels down the alignment pipeline
    typedef struct packed {
        logic data;
        logic viol;
        logic pos;
        logic neg;
    } lcd_sym_t;

    // history the classifier keeps between symbols
    typedef struct packed {
        logic              have_pulse;  // any pulse seen since reset
        logic              last_neg;    // polarity of last pulse, 1 = negative
        logic              have_bpv;    // any violation pulse seen since reset
        logic              bpv_neg;     // polarity of last violation pulse
        logic              prev_valid;  // last pulse was a valid B
        logic [ZRUN_W-1:0] zrun;        // zeros since last pulse, saturating
    } lcd_state_t;

endpackage

// File: rtl/lcd_symbol_classifier.sv
module lcd_symbol_classifier
    import lcd_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pos_i,
    input  logic               neg_i,
    input  logic               binary_sel_i,
    input  logic               hdb3_sel_i,
    input  logic               exz_mask_i,
    output lcd_sym_t           sym_o,
    output logic [LATENCY-2:0] clr_o
);

    lcd_state_t st_d, st_q;

    logic              pulse;
    logic              both;
    logic              is_bpv;
    logic              same_bpv;
    logic [ZRUN_W-1:0] subst_len;

    always_comb begin
        st_d      = st_q;
        sym_o     = '0;
        clr_o     = '0;
        subst_len = hdb3_sel_i ? ZRUN_W'(HDB3_LEN) : ZRUN_W'(B3ZS_LEN);
        pulse     = pos_i ^ neg_i;
        both      = pos_i & neg_i;
        is_bpv    = pulse && st_q.have_pulse && (neg_i == st_q.last_neg);
        same_bpv  = st_q.have_bpv && (neg_i == st_q.bpv_neg);

        if (!binary_sel_i) begin
            // bipolar format: raw pass-through, history frozen
            sym_o.pos = pos_i;
            sym_o.neg = neg_i;
        end else if (both) begin
            // ambiguous symbol: a one that is always a violation
            sym_o.data      = 1'b1;
            sym_o.viol      = 1'b1;
            st_d.zrun       = '0;
            st_d.prev_valid = 1'b0;
        end else if (pulse) begin
            st_d.zrun       = '0;
            st_d.have_pulse = 1'b1;
            st_d.last_neg   = neg_i;
            if (!is_bpv) begin
                sym_o.data      = 1'b1;
                st_d.prev_valid = 1'b1;
            end else begin
                st_d.prev_valid = 1'b0;
                st_d.have_bpv   = 1'b1;
                st_d.bpv_neg    = neg_i;
                if (st_q.zrun >= subst_len - 1'b1) begin
                    // all-zero substitution code closes here
                    sym_o.viol = same_bpv;
                end else if (st_q.zrun == subst_len - 2'd2) begin
                    // code opened by a pulse: remove that pulse retroactively
                    sym_o.viol = same_bpv;
                    if (st_q.prev_valid) begin
                        if (hdb3_sel_i) clr_o[2] = 1'b1;
                        else            clr_o[1] = 1'b1;
                    end
                end else begin
                    // genuine violation too close to the previous pulse
                    sym_o.data = 1'b1;
                    sym_o.viol = 1'b1;
                end
            end
        end else begin
            if (st_q.zrun == subst_len - 1'b1) sym_o.viol = !exz_mask_i;
            if (st_q.zrun != '1) st_d.zrun = st_q.zrun + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    exz_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (binary_sel_i && exz_mask_i && !pos_i && !neg_i) |-> !sym_o.viol);

    // R8 R9
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));

    // R8 R9
    clr_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_o) |-> (binary_sel_i && (pos_i ^ neg_i) && !sym_o.data));

endmodule

// File: rtl/lcd_align_pipe.sv
module lcd_align_pipe
    import lcd_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lcd_sym_t           sym_i,
    input  logic [LATENCY-2:0] clr_i,
    output lcd_sym_t           sym_o
);

    lcd_sym_t stage_d [LATENCY];
    lcd_sym_t stage_q [LATENCY];

    always_comb begin
        stage_d[0] = sym_i;
        for (int i = 1; i < LATENCY; i++) begin
            stage_d[i] = stage_q[i-1];
            if (clr_i[i-1]) stage_d[i].data = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LATENCY; i++) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_d[i];
        end
    end

    assign sym_o = stage_q[LATENCY-1];

    for (genvar k = 0; k < LATENCY - 1; k++) begin : g_clr_chk
        // R8 R9
        clear_kills_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[k] |=> !stage_q[k+1].data);
    end

endmodule

// File: rtl/line_code_decoder.sv
module line_code_decoder
    import lcd_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    input  logic binary_sel_i,
    input  logic hdb3_sel_i,
    input  logic exz_mask_i,
    output logic data_o,
    output logic viol_o,
    output logic pos_o,
    output logic neg_o
);

    lcd_sym_t           sym_in;
    lcd_sym_t           sym_out;
    logic [LATENCY-2:0] clr;

    lcd_symbol_classifier #(.LATENCY(LATENCY)) i_classifier (
        .clk          (clk),
        .rst_n        (rst_n),
        .pos_i        (pos_i),
        .neg_i        (neg_i),
        .binary_sel_i (binary_sel_i),
        .hdb3_sel_i   (hdb3_sel_i),
        .exz_mask_i   (exz_mask_i),
        .sym_o        (sym_in),
        .clr_o        (clr)
    );

    lcd_align_pipe #(.LATENCY(LATENCY)) i_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .sym_i (sym_in),
        .clr_i (clr),
        .sym_o (sym_out)
    );

    assign data_o = sym_out.data;
    assign viol_o = sym_out.viol;
    assign pos_o  = sym_out.pos;
    assign neg_o  = sym_out.neg;

    // R1 R2
    format_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o || neg_o) |-> !(data_o || viol_o));

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !(data_o || viol_o || pos_o || neg_o));

endmodule

// File: tb/test_line_code_decoder.sv
module test_line_code_decoder;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, pos_i, neg_i, binary_sel_i, hdb3_sel_i, exz_mask_i;
    logic data_o, viol_o, pos_o, neg_o;

    int checks = 0;
    int errors = 0;

    line_code_decoder i_line_code_decoder (
        .clk(clk), .rst_n(rst_n), .pos_i(pos_i), .neg_i(neg_i),
        .binary_sel_i(binary_sel_i), .hdb3_sel_i(hdb3_sel_i), .exz_mask_i(exz_mask_i),
        .data_o(data_o), .viol_o(viol_o), .pos_o(pos_o), .neg_o(neg_o)
    );

    // entry = {pos, neg, exp_data, exp_viol, exp_pos, exp_neg}
    localparam int NVEC = 63;
    localparam logic [5:0] VEC [NVEC] = '{
        // seg 0: B3ZS, excess zeros flagged
        6'b10_10_00, 6'b01_10_00, 6'b00_00_00, 6'b00_00_00, 6'b01_00_00,
        6'b10_00_00, 6'b00_00_00, 6'b10_00_00, 6'b01_10_00, 6'b01_11_00,
        6'b10_10_00, 6'b00_00_00, 6'b00_00_00, 6'b10_00_00, 6'b01_10_00,
        6'b10_10_00, 6'b00_00_00, 6'b00_00_00, 6'b10_01_00, 6'b00_00_00,
        6'b00_00_00, 6'b00_01_00, 6'b11_11_00, 6'b01_10_00,
        // seg 1: HDB3, excess zeros flagged
        6'b10_10_00, 6'b00_00_00, 6'b00_00_00, 6'b00_00_00, 6'b10_00_00,
        6'b01_00_00, 6'b00_00_00, 6'b00_00_00, 6'b01_00_00, 6'b10_10_00,
        6'b00_00_00, 6'b10_11_00, 6'b01_10_00, 6'b01_11_00, 6'b00_00_00,
        6'b00_00_00, 6'b00_00_00, 6'b00_01_00, 6'b00_00_00, 6'b10_10_00,
        // seg 2: HDB3, excess zeros masked
        6'b01_10_00, 6'b00_00_00, 6'b00_00_00, 6'b00_00_00, 6'b00_00_00,
        6'b00_00_00, 6'b10_10_00, 6'b10_11_00,
        // seg 3: B3ZS, excess zeros masked
        6'b10_10_00, 6'b00_00_00, 6'b00_00_00, 6'b00_00_00, 6'b00_00_00,
        6'b01_10_00, 6'b01_11_00,
        // seg 4: bipolar pass-through
        6'b10_00_10, 6'b01_00_01, 6'b11_00_11, 6'b01_00_01
    };

    localparam int NSEG = 5;
    localparam int         SEG_START [NSEG] = '{0, 24, 44, 52, 59};
    localparam int         SEG_LEN   [NSEG] = '{24, 20, 8, 7, 4};
    // {binary_sel, hdb3_sel, exz_mask}
    localparam logic [2:0] SEG_CFG   [NSEG] = '{3'b100, 3'b110, 3'b111, 3'b101, 3'b000};

    function automatic string seg_tag(int s);
        case (s)
            0:       return "R2 R3 R5 R6 R8 R10 R11";
            1:       return "R4 R5 R6 R9 R11";
            2:       return "R7 R4 R11";
            3:       return "R7 R3 R11";
            default: return "R1 R11";
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got {data,viol,pos,neg}=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pos_i = 1'b0;
        neg_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_seg(int s);
        {binary_sel_i, hdb3_sel_i, exz_mask_i} = SEG_CFG[s];
        do_reset();
        for (int k = 0; k < SEG_LEN[s] + 4; k++) begin
            if (k >= 4) begin
                logic [5:0] e;
                e = VEC[SEG_START[s] + k - 4];
                check($sformatf("seg %0d entry %0d (%s)", s, k - 4, seg_tag(s)),
                      {data_o, viol_o, pos_o, neg_o}, e[3:0]);
            end
            if (k < SEG_LEN[s]) {pos_i, neg_i} = VEC[SEG_START[s] + k][5:4];
            else                {pos_i, neg_i} = 2'b00;
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        pos_i = 1'b0;
        neg_i = 1'b0;
        {binary_sel_i, hdb3_sel_i, exz_mask_i} = 3'b100;

        // R12: outputs stay low while reset is held, even with pulses applied
        repeat (2) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            pos_i = k[0];
            neg_i = ~k[0];
            @(negedge clk);
            check("reset hold R12", {data_o, viol_o, pos_o, neg_o}, 4'b0000);
        end

        for (int s = 0; s < NSEG; s++) run_seg(s);

        // R11: a lone pulse is absent for three cycles, present on the fourth
        {binary_sel_i, hdb3_sel_i, exz_mask_i} = 3'b100;
        do_reset();
        pos_i = 1'b1;
        @(negedge clk);
        pos_i = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            check($sformatf("latency R11 cycle %0d", k), {data_o, viol_o, pos_o, neg_o}, 4'b0000);
            @(negedge clk);
        end
        check("latency R11 cycle 4", {data_o, viol_o, pos_o, neg_o}, 4'b1000);

        // R12: reset clears pulse history, so a repeated polarity is valid again
        pos_i = 1'b1;
        @(negedge clk);
        pos_i = 1'b0;
        do_reset();
        pos_i = 1'b1;
        @(negedge clk);
        pos_i = 1'b0;
        repeat (3) @(negedge clk);
        check("history cleared R12 R3", {data_o, viol_o, pos_o, neg_o}, 4'b1000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R11: got no completion, expected end of test");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule